// File: doc/BRIEF.md
# Secure Register Lock Controller

This block holds a bank of security-critical configuration registers and a lock store that decides, register by register, whether software may still read or write each one. Trusted start-up code fills the registers, then sets lock bits. From then on, a blocked access leaves the register unchanged, returns zeros for a read, and raises an error flag. The lock store can also lock itself, so later software cannot add or change protection.

Two status inputs report debug mode (debug unlocked) and scan mode. The block does not let either input clear, reset or bypass the lock state. Only the two real resets can do that: the power-on reset and the secondary system reset. Both are active-low and asynchronous.

Top module: `seclk_top`

## Requirements
- R1: While either `rstPorN` or `rstSysN` is low, every protected register, every lock bit, `rdData` and `err` are zero. The resets act without waiting for a clock edge.
- R2: Protected register i sits at address i, for i from 0 to 7. The lock store sits at address 8. A read of any other address returns zero and raises `err`. A write to any other address changes nothing and raises `err`.
- R3: `rdData` is registered. It shows the value selected by a read on the clock edge that samples `rdEn`. It keeps that value until the next read.
- R4: The lock store holds these bits: write locks in bits [7:0] (bit i covers register i), read locks in bits [15:8] (bit 8+i covers register i), and the self-lock in bit 16. A write to the lock store ORs the data into the stored bits. A 0 never clears a set bit before reset. A read returns the stored bits, zero-extended.
- R5: A write to a register whose write-lock bit is 1 leaves the register unchanged and raises `err`.
- R6: A read of a register whose read-lock bit is 1 returns all zeros and raises `err`.
- R7: Once the self-lock bit is 1, a write to the lock store changes nothing and raises `err`. Reads of the lock store are still allowed.
- R8: `dbgUnlock` and `scanMode` have no effect at any level or on any transition. They never change a lock bit, and they never allow a blocked read or write.
- R9: The secondary reset `rstSysN` clears the registers and all lock bits in exactly the same way as the power-on reset.
- R10: `err` is registered. It is high in the cycle after a refused access and low in the cycle after a permitted access or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPorN | input | 1 | Power-on reset, active-low, asynchronous |
| rstSysN | input | 1 | Secondary system reset, active-low, asynchronous |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| dbgUnlock | input | 1 | Debug-unlocked status (no effect on the lock state) |
| scanMode | input | 1 | Scan mode status (no effect on the lock state) |
| rdData | output | 32 | Registered read data |
| err | output | 1 | Registered error flag for a refused access |

## Verification
The assertions check four things on every cycle:
- Lock bits only ever rise.
- The lock store is frozen once the self-lock is set.
- A read-locked read returns zeros together with the error flag.
- A write-locked write, or any error, follows a real access.

These properties hold whatever the debug and scan inputs do, which covers R8 on every cycle. Only the bench scenarios can show three things:
- Register contents survive a refused write, because the readback path is the only view of them.
- An asynchronous assertion of either reset clears everything, both locks and data.
- A long stretch in debug mode leaves the stored lock pattern intact.

// File: rtl/seclk_pkg.sv
package seclk_pkg;

  // Per-cycle strobes from the access control to the storage datapath
  typedef struct packed {
    logic regWr;     // write the addressed protected register
    logic lockWr;    // OR write data into the lock store
    logic rdLoad;    // update the read data register
    logic rdSrcLock; // read source is the lock store
    logic rdBlank;   // return zeros instead of stored data
    logic err;       // refused access this cycle
  } seclkStrobes_t;

endpackage

// File: rtl/seclk_ctrl.sv
module seclk_ctrl
  import seclk_pkg::*;
#(
  parameter int NumRegs = 8,
  parameter int AddrW   = 4
) (
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [AddrW-1:0]   addr,
  input  logic [NumRegs-1:0] lockWrBits,
  input  logic [NumRegs-1:0] lockRdBits,
  input  logic               selfLock,
  output seclkStrobes_t      strobes
);

  localparam int IdxW = (NumRegs > 1) ? $clog2(NumRegs) : 1;

  logic            isReg;
  logic            isLock;
  logic [IdxW-1:0] idx;
  logic            wrLocked;
  logic            rdLocked;
  logic            wrRefused;
  logic            rdRefused;

  always_comb begin
    isReg  = addr < AddrW'(NumRegs);
    isLock = addr == AddrW'(NumRegs);
    idx    = addr[IdxW-1:0];

    wrLocked = isReg && lockWrBits[idx];
    rdLocked = isReg && lockRdBits[idx];

    wrRefused = wrEn && (wrLocked || (isLock && selfLock) || (!isReg && !isLock));
    rdRefused = rdEn && (rdLocked || (!isReg && !isLock));

    strobes.regWr     = wrEn && isReg && !wrLocked;
    strobes.lockWr    = wrEn && isLock && !selfLock;
    strobes.rdLoad    = rdEn;
    strobes.rdSrcLock = isLock;
    strobes.rdBlank   = rdRefused;
    strobes.err       = wrRefused || rdRefused;
  end

endmodule

// File: rtl/seclk_datapath.sv
module seclk_datapath
  import seclk_pkg::*;
#(
  parameter int NumRegs = 8,
  parameter int DataW   = 32,
  parameter int AddrW   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  seclkStrobes_t      strobes,
  input  logic [AddrW-1:0]   addr,
  input  logic [DataW-1:0]   wrData,
  output logic [NumRegs-1:0] lockWrBits,
  output logic [NumRegs-1:0] lockRdBits,
  output logic               selfLock,
  output logic [DataW-1:0]   rdData,
  output logic               err
);

  localparam int IdxW  = (NumRegs > 1) ? $clog2(NumRegs) : 1;
  localparam int LockW = 2 * NumRegs + 1;

  logic [DataW-1:0] regQ [NumRegs];
  logic [LockW-1:0] lockQ;
  logic [DataW-1:0] rdNext;
  logic [IdxW-1:0]  idx;

  assign idx = addr[IdxW-1:0];

  // Protected register bank, one write port
  for (genvar g = 0; g < NumRegs; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[g] <= '0;
      end else if (strobes.regWr && idx == IdxW'(g)) begin
        regQ[g] <= wrData;
      end
    end
  end

  // Lock store: set-only, cleared by real resets alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= '0;
    end else if (strobes.lockWr) begin
      lockQ <= lockQ | wrData[LockW-1:0];
    end
  end

  always_comb begin
    if (strobes.rdBlank) begin
      rdNext = '0;
    end else if (strobes.rdSrcLock) begin
      rdNext = DataW'(lockQ);
    end else begin
      rdNext = regQ[idx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      err    <= 1'b0;
    end else begin
      err <= strobes.err;
      if (strobes.rdLoad) begin
        rdData <= rdNext;
      end
    end
  end

  assign lockWrBits = lockQ[NumRegs-1:0];
  assign lockRdBits = lockQ[2*NumRegs-1:NumRegs];
  assign selfLock   = lockQ[2*NumRegs];

endmodule

// File: rtl/seclk_top.sv
module seclk_top
  import seclk_pkg::*;
#(
  parameter int NumRegs = 8,
  parameter int DataW   = 32,
  parameter int AddrW   = 4
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             rstSysN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  input  logic             dbgUnlock,
  input  logic             scanMode,
  output logic [DataW-1:0] rdData,
  output logic             err
);

  logic               rstN;
  logic [NumRegs-1:0] lockWrBits;
  logic [NumRegs-1:0] lockRdBits;
  logic               selfLock;
  seclkStrobes_t      strobes;
  logic               unusedModeBits;

  // Only the true reset inputs form the reset term
  assign rstN = rstPorN & rstSysN;

  // Debug and scan status deliberately reach no state or gating
  assign unusedModeBits = dbgUnlock ^ scanMode;

  seclk_ctrl #(
    .NumRegs(NumRegs),
    .AddrW  (AddrW)
  ) u_ctrl (
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .lockWrBits(lockWrBits),
    .lockRdBits(lockRdBits),
    .selfLock  (selfLock),
    .strobes   (strobes)
  );

  seclk_datapath #(
    .NumRegs(NumRegs),
    .DataW  (DataW),
    .AddrW  (AddrW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addr      (addr),
    .wrData    (wrData),
    .lockWrBits(lockWrBits),
    .lockRdBits(lockRdBits),
    .selfLock  (selfLock),
    .rdData    (rdData),
    .err       (err)
  );

endmodule

// File: rtl/seclk_chk.sv
module seclk_chk #(
  parameter int NumRegs = 8,
  parameter int DataW   = 32,
  parameter int AddrW   = 4
) (
  input logic               clk,
  input logic               rstPorN,
  input logic               rstSysN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [AddrW-1:0]   addr,
  input logic [DataW-1:0]   rdData,
  input logic               err,
  input logic [NumRegs-1:0] lockWrBits,
  input logic [NumRegs-1:0] lockRdBits,
  input logic               selfLock
);

  localparam int IdxW = (NumRegs > 1) ? $clog2(NumRegs) : 1;

  logic [2*NumRegs:0] allLocks;
  logic               inBank;
  logic [IdxW-1:0]    idx;

  assign allLocks = {selfLock, lockRdBits, lockWrBits};
  assign inBank   = addr < AddrW'(NumRegs);
  assign idx      = addr[IdxW-1:0];

  // R4 R8
  locks_sticky_chk: assert property (@(posedge clk) disable iff (!(rstPorN && rstSysN))
    1'b1 |=> ((allLocks & $past(allLocks)) == $past(allLocks)));

  // R7
  self_lock_freeze_chk: assert property (@(posedge clk) disable iff (!(rstPorN && rstSysN))
    selfLock |=> $stable(allLocks));

  // R6
  rd_locked_blank_chk: assert property (@(posedge clk) disable iff (!(rstPorN && rstSysN))
    (rdEn && inBank && lockRdBits[idx]) |=> (rdData == '0 && err));

  // R5
  wr_locked_err_chk: assert property (@(posedge clk) disable iff (!(rstPorN && rstSysN))
    (wrEn && inBank && lockWrBits[idx]) |=> err);

  // R10
  err_after_access_chk: assert property (@(posedge clk) disable iff (!(rstPorN && rstSysN))
    err |-> $past(rdEn || wrEn));

endmodule

bind seclk_top seclk_chk #(
  .NumRegs(NumRegs),
  .DataW  (DataW),
  .AddrW  (AddrW)
) u_chk (
  .clk       (clk),
  .rstPorN   (rstPorN),
  .rstSysN   (rstSysN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData),
  .err       (err),
  .lockWrBits(lockWrBits),
  .lockRdBits(lockRdBits),
  .selfLock  (selfLock)
);

// File: tb/tb_seclk_top.sv
`timescale 1ns/1ps
module tb_seclk_top;

  logic        clk = 1'b0;
  logic        rstPorN = 1'b0;
  logic        rstSysN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        dbgUnlock = 1'b0;
  logic        scanMode = 1'b0;
  logic [31:0] rdData;
  logic        err;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  seclk_top dut (
    .clk(clk), .rstPorN(rstPorN), .rstSysN(rstSysN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .dbgUnlock(dbgUnlock), .scanMode(scanMode),
    .rdData(rdData), .err(err)
  );

  // op: 0 idle, 1 write, 2 read
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  a;
    logic [31:0] wd;
    logic        dbg;
    logic        scan;
    logic        expErr;
    logic        chkRd;
    logic [31:0] expRd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 4'd0,  32'hA5A5_0001, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         8'd3},  // R3 write r0
    '{2'd2, 4'd0,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'hA5A5_0001, 8'd3},  // R3 read back
    '{2'd1, 4'd3,  32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         8'd2},  // R2 write r3
    '{2'd1, 4'd8,  32'h0000_0801, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         8'd4},  // R4 wlock r0, rlock r3
    '{2'd2, 4'd8,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0801, 8'd4},  // R4 lock readback
    '{2'd1, 4'd0,  32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,         8'd8},  // R8 debug write blocked
    '{2'd2, 4'd0,  32'h0,         1'b1, 1'b0, 1'b0, 1'b1, 32'hA5A5_0001, 8'd5},  // R5 unchanged
    '{2'd2, 4'd3,  32'h0,         1'b1, 1'b0, 1'b1, 1'b1, 32'h0,         8'd6},  // R6 read-locked
    '{2'd1, 4'd8,  32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         8'd4},  // R4 write 0 no clear
    '{2'd2, 4'd8,  32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0801, 8'd4},  // R4 still set
    '{2'd1, 4'd0,  32'h0,         1'b0, 1'b1, 1'b1, 1'b0, 32'h0,         8'd8},  // R8 scan write blocked
    '{2'd2, 4'd0,  32'h0,         1'b0, 1'b1, 1'b0, 1'b1, 32'hA5A5_0001, 8'd8},  // R8 unchanged
    '{2'd1, 4'd5,  32'hCAFE_F00D, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         8'd10}, // R10 ok write
    '{2'd1, 4'd8,  32'h0001_0020, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         8'd7},  // R7 self-lock + wlock r5
    '{2'd1, 4'd8,  32'h0000_0004, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         8'd7},  // R7 refused
    '{2'd2, 4'd8,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'h0001_0821, 8'd7},  // R7 unchanged
    '{2'd1, 4'd5,  32'h0,         1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         8'd5},  // R5 blocked
    '{2'd2, 4'd5,  32'h0,         1'b0, 1'b0, 1'b0, 1'b1, 32'hCAFE_F00D, 8'd5},  // R5 kept
    '{2'd2, 4'd12, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 32'h0,         8'd2},  // R2 unmapped
    '{2'd1, 4'd7,  32'h0000_0007, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,         8'd10}, // R10 ok write
    '{2'd2, 4'd7,  32'h0,         1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0007, 8'd3}   // R3 read
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  // Issue a read at a negedge, sample at the following negedge
  task automatic readAt(input logic [3:0] a, output logic [31:0] d, output logic e);
    addr = a; rdEn = 1'b1; wrEn = 1'b0;
    @(negedge clk);
    d = rdData; e = err;
    idle();
  endtask

  task automatic writeAt(input logic [3:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #100000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        e;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdData in reset", rdData, 32'h0);
    check("R1 err in reset", {31'b0, err}, 32'h0);
    rstPorN = 1'b1; rstSysN = 1'b1;
    @(negedge clk);
    readAt(4'd8, d, e);
    check("R1 locks clear after reset", d, 32'h0);

    // Table walk: one vector per cycle
    for (int i = 0; i < NV; i++) begin
      wrEn = (VEC[i].op == 2'd1);
      rdEn = (VEC[i].op == 2'd2);
      addr = VEC[i].a;
      wrData = VEC[i].wd;
      dbgUnlock = VEC[i].dbg;
      scanMode = VEC[i].scan;
      @(negedge clk);
      check($sformatf("R%0d/R10 err vec %0d", VEC[i].req, i), {31'b0, err}, {31'b0, VEC[i].expErr});
      if (VEC[i].chkRd)
        check($sformatf("R%0d rdData vec %0d", VEC[i].req, i), rdData, VEC[i].expRd);
    end
    idle();
    dbgUnlock = 1'b0; scanMode = 1'b0;
    @(negedge clk);
    check("R10 err low after idle", {31'b0, err}, 32'h0);

    // R8: toggle debug and scan for many cycles, locks must persist
    for (int k = 0; k < 20; k++) begin
      dbgUnlock = k[0]; scanMode = k[1];
      @(negedge clk);
    end
    dbgUnlock = 1'b0; scanMode = 1'b0;
    readAt(4'd8, d, e);
    check("R8 locks survive debug/scan", d, 32'h0001_0821);

    // R9: secondary reset asserted mid-cycle clears everything asynchronously
    #1 rstSysN = 1'b0;
    #0.5;
    check("R9 rdData cleared async", rdData, 32'h0);
    @(negedge clk);
    rstSysN = 1'b1;
    @(negedge clk);
    readAt(4'd8, d, e);
    check("R9 locks cleared", d, 32'h0);
    readAt(4'd5, d, e);
    check("R9 register cleared", d, 32'h0);
    writeAt(4'd5, 32'h0BAD_CAFE);
    readAt(4'd5, d, e);
    check("R9 register writable again", d, 32'h0BAD_CAFE);

    // R1: power-on reset also clears locks and data
    writeAt(4'd8, 32'h0000_0002);
    writeAt(4'd1, 32'h1111_1111);
    check("R5 err after locked write", {31'b0, err}, 32'h1);
    rstPorN = 1'b0;
    @(negedge clk);
    rstPorN = 1'b1;
    @(negedge clk);
    readAt(4'd5, d, e);
    check("R1 POR clears register", d, 32'h0);
    writeAt(4'd1, 32'h2222_2222);
    check("R1 write allowed after POR", {31'b0, err}, 32'h0);
    readAt(4'd1, d, e);
    check("R1 POR cleared write lock", d, 32'h2222_2222);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule